// File: doc/BRIEF.md
# Extended Parallel Port Host Register Decoder

This block is the host-facing register front end of an extended-capabilities parallel port. A host bus presents a 16-bit address, read and write strobes, a write byte and an address-enable qualifier. The block compares the address against a fixed base and picks one of six register slots: base, base+1, base+2, base+0x400, base+0x401 and base+0x402. What a slot means depends on the mode field held in the extended control register. The same slot can be the data latch in one mode, an entry point into a FIFO in another, and inert in a third.

The block holds the data latch that drives the port pins, a control register whose bit 5 sets the port direction, a second configuration register, and the extended control register. It also reports a fixed configuration byte and the live status lines. Host writes go into one shared 16-entry transmit FIFO. Each entry carries a byte plus a tag bit: 1 means address/run-length and 0 means data. The FIFO drains through a valid/pop interface toward the peripheral-side engine, which is not part of this block. In test mode, the host drains the FIFO itself by reading it.

Top module: `ecp_regdec`

## Requirements
- R1: After synchronous reset, the data latch and pins read 0x00, the mode is 000, the control register is 0 (direction forward, so `pd_oe` is 1), the FIFO is empty, and the extended control register reads 0x01.
- R2: While `bus_aen` is 1, no read or write has any effect, and `bus_rdata` is 0x00.
- R3: In modes 000 and 001, a write to base+0 loads the data latch, and `pd_out` shows that byte on the next cycle. A read of base+0 returns `pd_in`.
- R4: In modes other than 000 and 001, a write to base+0 leaves the data latch unchanged. A read of base+0 returns 0x00 in those modes.
- R5: In mode 011, a write to base+0 pushes the byte with tag 1, but only while control bit 5 (direction) is 0. When that bit is 1, the write is dropped.
- R6: In modes 010 and 011, a write to base+0x400 pushes the byte with tag 0. The same write in any mode other than 010, 011 or 110 pushes nothing.
- R7: In every mode, base+1 reads {`sts_in`[4:0], 3'b000} and ignores writes. Base+2 holds six writable bits, [5:0], and reads back {2'b00, ctrl[5:0]}.
- R8: In mode 111, base+0x400 reads the constant `CFGA_VAL` and ignores writes. Base+0x401 is a read/write byte that is reachable in mode 111 only, and reads as 0x00 in other modes.
- R9: In every mode, base+0x402 takes the mode from bits [7:5] and stores bits [4:2]. It reads back {mode, bits[4:2], full, empty}, and bits 1:0 come from the FIFO state only.
- R10: The FIFO delivers entries in push order on `fifo_byte`/`fifo_tag` while `fifo_valid` is 1. A push while 16 entries are held is dropped and leaves the stored entries intact.
- R11: In mode 110, `fifo_valid` is 0 and `fifo_pop` is ignored. A write to base+0x400 pushes with tag 0. A read of base+0x400 returns the oldest byte (0x00 when empty) and removes it.
- R12: An address that matches none of the six slots has no effect and reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Host address |
| bus_aen | input | 1 | Address-enable qualifier; 1 blocks every access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe (one cycle per access) |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational while `bus_rd` is high |
| pd_in | input | 8 | Sampled port pin values |
| pd_out | output | 8 | Data latch driven to the port pins |
| pd_oe | output | 1 | Pin drive enable, 1 when direction is forward |
| sts_in | input | 5 | Peripheral status lines |
| fifo_valid | output | 1 | FIFO head present for the drain side |
| fifo_byte | output | 8 | Byte at the FIFO head |
| fifo_tag | output | 1 | Tag at the FIFO head, 1 = address/run-length |
| fifo_pop | input | 1 | Drain side removes the head entry |

## Verification
The hardest state to reach is a full FIFO while mode and direction are changing. The stimulus first sets the reverse direction in ECP mode and attempts address-tagged writes, which must vanish. It then writes eighteen bytes to fill the FIFO past capacity and confirms that the flags read back and that the surviving order is intact. Finally it switches into test mode with entries still queued, so that pops from the drain port must be ignored while host reads at base+0x400 empty the FIFO one entry at a time.

// File: rtl/ecp_regdec_pkg.sv
package ecp_regdec_pkg;

    typedef enum logic [2:0] {
        MODE_SPP = 3'b000,
        MODE_BID = 3'b001,
        MODE_PPF = 3'b010,
        MODE_ECP = 3'b011,
        MODE_EPP = 3'b100,
        MODE_RSV = 3'b101,
        MODE_TST = 3'b110,
        MODE_CFG = 3'b111
    } mode_e;

    typedef enum logic [2:0] {
        SLOT_LO0  = 3'd0,
        SLOT_LO1  = 3'd1,
        SLOT_LO2  = 3'd2,
        SLOT_HI0  = 3'd3,
        SLOT_HI1  = 3'd4,
        SLOT_HI2  = 3'd5,
        SLOT_NONE = 3'd7
    } slot_e;

    typedef enum logic [3:0] {
        ACC_NONE,
        ACC_DATA,
        ACC_AFIFO,
        ACC_STAT,
        ACC_CTRL,
        ACC_DFIFO,
        ACC_TFIFO,
        ACC_CFGA,
        ACC_CFGB,
        ACC_ECR
    } acc_e;

    typedef struct packed {
        logic       tag;
        logic [7:0] byte_v;
    } fifo_ent_t;

    localparam logic [15:0] OFS_HIGH = 16'h0400;
    localparam int          DIR_BIT  = 5;

    function automatic acc_e map_access(slot_e slot, mode_e mode, logic is_wr);
        acc_e a;
        a = ACC_NONE;
        case (slot)
            SLOT_LO0: begin
                if (mode == MODE_SPP || mode == MODE_BID) a = ACC_DATA;
                else if (mode == MODE_ECP && is_wr)      a = ACC_AFIFO;
            end
            SLOT_LO1: a = ACC_STAT;
            SLOT_LO2: a = ACC_CTRL;
            SLOT_HI0: begin
                if ((mode == MODE_PPF || mode == MODE_ECP) && is_wr) a = ACC_DFIFO;
                else if (mode == MODE_TST)                          a = ACC_TFIFO;
                else if (mode == MODE_CFG && !is_wr)                a = ACC_CFGA;
            end
            SLOT_HI1: if (mode == MODE_CFG) a = ACC_CFGB;
            SLOT_HI2: a = ACC_ECR;
            default:  a = ACC_NONE;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/ecp_addr_decode.sv
module ecp_addr_decode
    import ecp_regdec_pkg::*;
#(
    parameter logic [15:0] BASE = 16'h0378
) (
    input  logic [15:0] addr,
    input  logic        aen,
    input  logic        rd,
    input  logic        wr,
    input  mode_e       mode,
    output acc_e        acc,
    output logic        rd_en,
    output logic        wr_en
);
    localparam logic [15:0] A_LO0 = BASE;
    localparam logic [15:0] A_LO1 = BASE + 16'd1;
    localparam logic [15:0] A_LO2 = BASE + 16'd2;
    localparam logic [15:0] A_HI0 = BASE + OFS_HIGH;
    localparam logic [15:0] A_HI1 = BASE + OFS_HIGH + 16'd1;
    localparam logic [15:0] A_HI2 = BASE + OFS_HIGH + 16'd2;

    slot_e slot;
    acc_e  raw;

    always_comb begin
        if      (addr == A_LO0) slot = SLOT_LO0;
        else if (addr == A_LO1) slot = SLOT_LO1;
        else if (addr == A_LO2) slot = SLOT_LO2;
        else if (addr == A_HI0) slot = SLOT_HI0;
        else if (addr == A_HI1) slot = SLOT_HI1;
        else if (addr == A_HI2) slot = SLOT_HI2;
        else                    slot = SLOT_NONE;
    end

    always_comb begin
        raw   = map_access(slot, mode, wr);
        rd_en = rd && !aen && (raw != ACC_NONE);
        wr_en = wr && !aen && (raw != ACC_NONE);
        acc   = (rd_en || wr_en) ? raw : ACC_NONE;
    end
endmodule

// File: rtl/ecp_tx_fifo.sv
module ecp_tx_fifo
    import ecp_regdec_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  fifo_ent_t                 push_ent,
    input  logic                      pop,
    output fifo_ent_t                 head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                      full,
    output logic                      empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    fifo_ent_t     mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + AW'(1);
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + AW'(1);
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end
endmodule

// File: rtl/ecp_regdec.sv
module ecp_regdec
    import ecp_regdec_pkg::*;
#(
    parameter logic [15:0] BASE     = 16'h0378,
    parameter int          DEPTH    = 16,
    parameter logic [7:0]  CFGA_VAL = 8'h10
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] bus_addr,
    input  logic        bus_aen,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  pd_in,
    output logic [7:0]  pd_out,
    output logic        pd_oe,
    input  logic [4:0]  sts_in,
    output logic        fifo_valid,
    output logic [7:0]  fifo_byte,
    output logic        fifo_tag,
    input  logic        fifo_pop
);
    localparam int CW = $clog2(DEPTH + 1);

    mode_e      mode;
    logic [2:0] ecr_mid;
    logic [5:0] ctrl;
    logic [7:0] data_q;
    logic [7:0] cfgb;
    logic       dir;

    acc_e       acc;
    logic       rd_en, wr_en;

    logic       push, push_tag, pop_req;
    fifo_ent_t  push_ent, head;
    logic [CW-1:0] fifo_count;
    logic       fifo_full, fifo_empty;

    assign dir = ctrl[DIR_BIT];

    ecp_addr_decode #(.BASE(BASE)) u_dec (
        .addr  (bus_addr),
        .aen   (bus_aen),
        .rd    (bus_rd),
        .wr    (bus_wr),
        .mode  (mode),
        .acc   (acc),
        .rd_en (rd_en),
        .wr_en (wr_en)
    );

    always_comb begin
        push_tag = (acc == ACC_AFIFO);
        push     = wr_en && ((push_tag && !dir) || acc == ACC_DFIFO || acc == ACC_TFIFO);
        push_ent = '{tag: push_tag, byte_v: bus_wdata};
        pop_req  = (rd_en && acc == ACC_TFIFO) || (fifo_pop && mode != MODE_TST);
    end

    ecp_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_ent (push_ent),
        .pop      (pop_req),
        .head     (head),
        .count    (fifo_count),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_SPP;
            ecr_mid <= '0;
            ctrl    <= '0;
            data_q  <= '0;
            cfgb    <= '0;
        end else if (wr_en) begin
            case (acc)
                ACC_DATA: data_q <= bus_wdata;
                ACC_CTRL: ctrl   <= bus_wdata[5:0];
                ACC_CFGB: cfgb   <= bus_wdata;
                ACC_ECR: begin
                    mode    <= mode_e'(bus_wdata[7:5]);
                    ecr_mid <= bus_wdata[4:2];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (acc)
                ACC_DATA:  bus_rdata = pd_in;
                ACC_STAT:  bus_rdata = {sts_in, 3'b000};
                ACC_CTRL:  bus_rdata = {2'b00, ctrl};
                ACC_TFIFO: bus_rdata = fifo_empty ? 8'h00 : head.byte_v;
                ACC_CFGA:  bus_rdata = CFGA_VAL;
                ACC_CFGB:  bus_rdata = cfgb;
                ACC_ECR:   bus_rdata = {mode, ecr_mid, fifo_full, fifo_empty};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign pd_out     = data_q;
    assign pd_oe      = !dir;
    assign fifo_valid = !fifo_empty && (mode != MODE_TST);
    assign fifo_byte  = head.byte_v;
    assign fifo_tag   = head.tag;
endmodule

// File: rtl/ecp_regdec_chk.sv
module ecp_regdec_chk #(
    parameter int DEPTH = 16
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       aen,
    input logic                       push,
    input logic                       push_tag,
    input logic                       dir,
    input logic                       pop,
    input logic [$clog2(DEPTH+1)-1:0] count,
    input logic                       full
);
    AST_AEN_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        aen |-> !push);                                              // R2

    AST_REV_NO_ADDR: assert property (@(posedge clk) disable iff (rst)
        (push && push_tag) |-> !dir);                                // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        count <= ($clog2(DEPTH+1))'(DEPTH));                         // R10

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> $stable(count));                  // R10

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!push && !pop) |=> $stable(count));                         // R10
endmodule

bind ecp_regdec ecp_regdec_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .aen      (bus_aen),
    .push     (push),
    .push_tag (push_tag),
    .dir      (dir),
    .pop      (pop_req),
    .count    (fifo_count),
    .full     (fifo_full)
);

// File: tb/ecp_regdec_tb.sv
`timescale 1ns/1ps
module ecp_regdec_tb;
    localparam logic [15:0] BASE = 16'h0378;
    localparam int          DEPTH = 16;
    localparam logic [7:0]  CFGA = 8'h10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_aen = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pd_in = 8'h00;
    logic [7:0]  pd_out;
    logic        pd_oe;
    logic [4:0]  sts_in = 5'h00;
    logic        fifo_valid;
    logic [7:0]  fifo_byte;
    logic        fifo_tag;
    logic        fifo_pop = 1'b0;

    int checks = 0, failures = 0;
    bit monitor_on = 0;

    // reference model state
    logic [7:0] m_data = 0, m_cfgb = 0;
    logic [5:0] m_ctrl = 0;
    logic [2:0] m_mode = 0, m_mid = 0;
    logic [8:0] m_q[$];

    always #2 clk = ~clk;

    ecp_regdec #(.BASE(BASE), .DEPTH(DEPTH), .CFGA_VAL(CFGA)) u_dut (.*);

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(logic [15:0] a, logic aen);
        logic [15:0] off;
        off = a - BASE;
        if (aen) return 8'h00;
        case (off)
            16'h000: return (m_mode <= 3'd1) ? pd_in : 8'h00;
            16'h001: return {sts_in, 3'b000};
            16'h002: return {2'b00, m_ctrl};
            16'h400: begin
                if (m_mode == 3'd6) return (m_q.size() > 0) ? m_q[0][7:0] : 8'h00;
                if (m_mode == 3'd7) return CFGA;
                return 8'h00;
            end
            16'h401: return (m_mode == 3'd7) ? m_cfgb : 8'h00;
            16'h402: return {m_mode, m_mid, m_q.size() == DEPTH, m_q.size() == 0};
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_write(logic [15:0] a, logic [7:0] d, logic aen);
        logic [15:0] off;
        off = a - BASE;
        if (aen) return;
        case (off)
            16'h000: begin
                if (m_mode <= 3'd1) m_data = d;
                else if (m_mode == 3'd3 && !m_ctrl[5] && m_q.size() < DEPTH)
                    m_q.push_back({1'b1, d});
            end
            16'h002: m_ctrl = d[5:0];
            16'h400: if ((m_mode == 3'd2 || m_mode == 3'd3 || m_mode == 3'd6)
                         && m_q.size() < DEPTH) m_q.push_back({1'b0, d});
            16'h401: if (m_mode == 3'd7) m_cfgb = d;
            16'h402: begin m_mode = d[7:5]; m_mid = d[4:2]; end
            default: ;
        endcase
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, logic aen = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_aen = aen; bus_wr = 1'b1;
        @(posedge clk); #1;
        model_write(a, d, aen);
        bus_wr = 1'b0; bus_aen = 1'b0;
    endtask

    task automatic rd(string req, logic [15:0] a, logic aen = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_aen = aen; bus_rd = 1'b1;
        #1 chk(req, bus_rdata, model_read(a, aen));
        @(posedge clk); #1;
        if (!aen && (a - BASE) == 16'h400 && m_mode == 3'd6 && m_q.size() > 0)
            void'(m_q.pop_front());
        bus_rd = 1'b0; bus_aen = 1'b0;
    endtask

    task automatic pop1();
        @(negedge clk);
        fifo_pop = 1'b1;
        @(posedge clk); #1;
        if (m_q.size() > 0 && m_mode != 3'd6) void'(m_q.pop_front());
        fifo_pop = 1'b0;
    endtask

    // every-cycle comparison of pins and FIFO head against the model (R3, R10, R11)
    always @(negedge clk) begin
        if (monitor_on) begin
            logic mv;
            mv = (m_q.size() > 0) && (m_mode != 3'd6);
            chk("R3_pins", pd_out, m_data);
            chk("R7_oe", {7'd0, pd_oe}, {7'd0, !m_ctrl[5]});
            chk("R11_valid", {7'd0, fifo_valid}, {7'd0, mv});
            if (mv) begin
                chk("R10_byte", fifo_byte, m_q[0][7:0]);
                chk("R10_tag", {7'd0, fifo_tag}, {7'd0, m_q[0][8]});
            end
        end
    end

    initial begin
        #800000;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        monitor_on = 1;
        // R1 reset state
        rd("R1_ecr", BASE + 16'h402);
        chk("R1_pins", pd_out, 8'h00);
        chk("R1_oe", {7'd0, pd_oe}, 8'h01);

        // R3 data latch in modes 000 and 001
        wr(BASE, 8'hA5);
        pd_in = 8'h3C;
        rd("R3_rd_spp", BASE);
        wr(BASE + 16'h402, 8'h20);
        wr(BASE, 8'h5A);
        pd_in = 8'hC3;
        rd("R3_rd_bid", BASE);

        // R2 address-enable gating
        wr(BASE, 8'hFF, 1'b1);
        wr(BASE + 16'h402, 8'hE0, 1'b1);
        rd("R2_aen_rd", BASE + 16'h402, 1'b1);
        rd("R2_mode_kept", BASE + 16'h402);

        // R12 unmapped addresses
        wr(BASE + 16'h0003, 8'h77);
        wr(BASE + 16'h0403, 8'h77);
        wr(BASE + 16'h0800, 8'h77);
        rd("R12_unmapped", BASE + 16'h0403);
        rd("R12_ecr_kept", BASE + 16'h402);

        // R4 offset 0 in other modes; R6 data FIFO in mode 010
        wr(BASE + 16'h402, 8'h40);
        wr(BASE, 8'h11);
        rd("R4_rd_ppf", BASE);
        wr(BASE + 16'h400, 8'h21);
        wr(BASE + 16'h400, 8'h22);
        wr(BASE + 16'h402, 8'h00);
        wr(BASE + 16'h400, 8'h23);
        rd("R6_ecr_two", BASE + 16'h402);

        // R5 address FIFO entry in mode 011
        wr(BASE + 16'h402, 8'h60);
        wr(BASE, 8'h31);
        rd("R4_rd_ecp", BASE);
        wr(BASE + 16'h002, 8'h20);
        wr(BASE, 8'h32);
        rd("R7_ctrl_rev", BASE + 16'h002);
        wr(BASE + 16'h002, 8'h00);
        wr(BASE + 16'h400, 8'h33);
        rd("R5_ecr", BASE + 16'h402);
        repeat (4) pop1();

        // R10 overfill and order
        for (int i = 0; i < DEPTH + 2; i++) wr(BASE + ((i % 3 == 0) ? 16'h000 : 16'h400), 8'h80 + 8'(i));
        rd("R10_full", BASE + 16'h402);
        repeat (3) pop1();
        rd("R9_after_pop", BASE + 16'h402);

        // R11 test mode: drain port blocked, host reads pop
        wr(BASE + 16'h402, 8'hC0);
        pop1();
        rd("R11_ecr", BASE + 16'h402);
        for (int i = 0; i < 5; i++) rd("R11_tfifo", BASE + 16'h400);
        wr(BASE + 16'h400, 8'h5E);

        // R7 status and control in several modes
        sts_in = 5'h15;
        rd("R7_sts_tst", BASE + 16'h001);
        wr(BASE + 16'h001, 8'hFF);
        wr(BASE + 16'h402, 8'hE0);
        wr(BASE + 16'h002, 8'hDF);
        rd("R7_ctrl", BASE + 16'h002);
        rd("R7_sts_cfg", BASE + 16'h001);
        wr(BASE + 16'h002, 8'h00);

        // R8 configuration registers
        rd("R8_cfga", BASE + 16'h400);
        wr(BASE + 16'h400, 8'h99);
        rd("R8_cfga_ro", BASE + 16'h400);
        wr(BASE + 16'h401, 8'h6B);
        rd("R8_cfgb", BASE + 16'h401);

        // R9 extended control: flag bits not writable
        wr(BASE + 16'h402, 8'hFF);
        rd("R9_ecr", BASE + 16'h402);
        wr(BASE + 16'h402, 8'h03);
        rd("R9_ecr_low", BASE + 16'h402);
        rd("R8_cfgb_hidden", BASE + 16'h401);
        rd("R3_data_rd", BASE);

        // drain the rest through the pop port
        while (m_q.size() > 0) pop1();
        rd("R10_empty", BASE + 16'h402);
        pop1();

        @(negedge clk);
        monitor_on = 0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule